// File: doc/BRIEF.md
# Micro-op Execution Port Dispatcher

This block sits between a pool of ready micro-ops and five execution ports. In every clock cycle it looks at up to five pool slots. Each slot carries a valid bit, a class code and a sequence tag. The block then decides, in the same cycle, which slots issue and to which port. Port 0 is shared: it holds the full-function integer unit and the floating-point unit. Port 1 holds a simple integer unit that does add, subtract and branch-target work. Ports 2, 3 and 4 take loads, store addresses and store data. A slot that is not granted stays in the pool and competes again in the next cycle.

The block tracks the floating-point result timing that decides which issues are legal. A reservation ring, indexed by future cycle, records which writeback cycles already hold a result. Add and multiply are pipelined, with latencies set by parameters. Divide and square root share one non-pipelined long-latency unit, and a small state machine tracks it. Its states are IDLE, DIV_BUSY and SQRT_BUSY:
- IDLE→DIV_BUSY when a divide issues.
- IDLE→SQRT_BUSY when a square root issues.
- DIV_BUSY→IDLE and SQRT_BUSY→IDLE when the remaining-cycle count reaches one.

When a floating-point result is due, the block pulses a completion output that carries the micro-op's tag.

Top module: `disp_port_steer`

## Requirements
- R1: Class codes are 0 simple integer, 1 full integer, 2 FP add, 3 FP multiply, 4 FP divide, 5 FP square root, 6 load, 7 store address and 8 store data. Codes 9 to 15 are never granted. Code 6 may issue only on port 2, code 7 only on port 3, code 8 only on port 4, and codes 1 to 5 only on port 0.
- R2: When several slots compete for a port, the slot with the numerically lowest tag wins. On equal tags the lower slot index wins. Losing slots are not granted in that cycle.
- R3: Port 1 takes the oldest valid simple-integer slot. Port 0 then takes the oldest remaining candidate among full-integer slots, eligible FP slots and simple-integer slots not taken by port 1. So a cycle issues two integers, or one integer and one FP micro-op, on these two ports, and never two FP micro-ops.
- R4: Grants are combinational in the cycle the inputs are presented. `port_fire[p]` is high exactly when port p issues, and `port_tag` field p then carries the tag of the winning slot. The number of set bits in `slot_grant` equals the number of set bits in `port_fire`.
- R5: An FP add granted in cycle t raises `done_valid` with its tag in cycle t+ADD_LAT (default 3).
- R6: An FP multiply granted in cycle t completes in cycle t+MUL_LAT (default 5).
- R7: A divide or square root granted in cycle t completes in cycle t+DIV_LAT or t+SQRT_LAT (defaults 18 and 29). While one is in flight, adds and multiplies still issue.
- R8: After a divide or square root is granted in cycle t, no divide or square root is granted in cycles t+1 to t+L-1, where L is its latency. One may be granted again from cycle t+L onward.
- R9: An FP micro-op whose completion cycle is already reserved by an earlier result is not granted. In that cycle port 0 may take another candidate.
- R10: During reset and in the first cycle after it, `done_valid` is low, the long unit is idle and no writeback cycle is reserved.
- R11: A slot whose valid bit is low is never granted, whatever its class and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | SLOTS | Per-slot ready flag |
| uop_class | input | SLOTS*4 | Per-slot class code; slot i uses bits [4i+3:4i] |
| uop_tag | input | SLOTS*TAG_W | Per-slot sequence tag; a lower value is older |
| slot_grant | output | SLOTS | Slot issues this cycle |
| port_fire | output | 5 | Port issues this cycle; bit 0 is the shared integer/FP port |
| port_tag | output | 5*TAG_W | Tag issued on each port; zero when the port is idle |
| done_valid | output | 1 | An FP result becomes available this cycle |
| done_tag | output | TAG_W | Tag of that result |

## Verification
A stale or missing bit in the reservation ring shows up at the ports in two ways. An FP micro-op may be held back with no reason, or it may issue while another is due. This differs from the reference in the grant of that same cycle, and later as a completion pulse in the wrong cycle or with the wrong tag. A long-unit state machine that leaves its busy states too early or too late is seen on the next divide or square root that is presented. That op gets a grant when none is due, or gets none when one is due. A mistake in age ordering is seen in the very cycle in which two slots compete for one port. Because the bench reference is compared every cycle, the first wrong grant is reported in the cycle it happens.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int CLASS_W   = 4;
    localparam int NUM_PORTS = 5;
    localparam int NUM_MEM   = 3;

    // micro-op class codes
    localparam logic [CLASS_W-1:0] UC_ALU      = 4'd0;
    localparam logic [CLASS_W-1:0] UC_ALU_FULL = 4'd1;
    localparam logic [CLASS_W-1:0] UC_FADD     = 4'd2;
    localparam logic [CLASS_W-1:0] UC_FMUL     = 4'd3;
    localparam logic [CLASS_W-1:0] UC_FDIV     = 4'd4;
    localparam logic [CLASS_W-1:0] UC_FSQRT    = 4'd5;
    localparam logic [CLASS_W-1:0] UC_LOAD     = 4'd6;
    localparam logic [CLASS_W-1:0] UC_STADDR   = 4'd7;
    localparam logic [CLASS_W-1:0] UC_STDATA   = 4'd8;

    // port numbering
    localparam int PORT_SHARED = 0;
    localparam int PORT_ALU    = 1;
    localparam int PORT_MEM0   = 2;

    typedef enum logic [1:0] {
        LS_IDLE      = 2'd0,
        LS_DIV_BUSY  = 2'd1,
        LS_SQRT_BUSY = 2'd2
    } longop_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [CLASS_W-1:0] mem_class(input int k);
        case (k)
            0:       return UC_LOAD;
            1:       return UC_STADDR;
            default: return UC_STDATA;
        endcase
    endfunction

endpackage

// File: rtl/disp_oldest_pick.sv
// Selects the requesting slot with the lowest tag; lower index wins a tie.
module disp_oldest_pick #(
    parameter int N     = 5,
    parameter int TAG_W = 6
) (
    input  logic [N-1:0]       req,
    input  logic [N*TAG_W-1:0] tags,
    output logic [N-1:0]       win,
    output logic               any,
    output logic [TAG_W-1:0]   win_tag
);

    always_comb begin
        win     = '0;
        any     = 1'b0;
        win_tag = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any || (tags[i*TAG_W +: TAG_W] < win_tag))) begin
                any     = 1'b1;
                win_tag = tags[i*TAG_W +: TAG_W];
                win     = '0;
                win[i]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/disp_wb_ring.sv
// Writeback reservation ring: entry j marks a result due j cycles from now.
module disp_wb_ring #(
    parameter int DEPTH  = 30,
    parameter int TAG_W  = 6,
    parameter int NPROBE = 4,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rsv_en,
    input  logic [IW-1:0]       rsv_idx,
    input  logic [TAG_W-1:0]    rsv_tag,
    input  logic [NPROBE*IW-1:0] probe_idx,
    output logic [NPROBE-1:0]   probe_free,
    output logic                head_valid,
    output logic [TAG_W-1:0]    head_tag
);

    logic [DEPTH-1:0] occ;
    logic [TAG_W-1:0] tagq [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= '0;
            for (int j = 0; j < DEPTH; j++) tagq[j] <= '0;
        end else begin
            for (int j = 0; j < DEPTH-1; j++) begin
                occ[j]  <= occ[j+1];
                tagq[j] <= tagq[j+1];
            end
            occ[DEPTH-1]  <= 1'b0;
            tagq[DEPTH-1] <= '0;
            if (rsv_en) begin
                occ[rsv_idx]  <= 1'b1;
                tagq[rsv_idx] <= rsv_tag;
            end
        end
    end

    for (genvar p = 0; p < NPROBE; p++) begin : g_probe
        assign probe_free[p] = !occ[probe_idx[p*IW +: IW]];
    end

    assign head_valid = occ[0];
    assign head_tag   = tagq[0];

endmodule

// File: rtl/disp_longop_fsm.sv
// Occupancy of the shared non-pipelined divide / square-root unit.
module disp_longop_fsm
    import disp_pkg::*;
#(
    parameter int DIV_LAT  = 18,
    parameter int SQRT_LAT = 29,
    localparam int CW      = $clog2(max_of(DIV_LAT, SQRT_LAT) + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_div,
    input  logic start_sqrt,
    output logic ready
);

    longop_state_e state, state_nxt;
    logic [CW-1:0] remain, remain_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= LS_IDLE;
            remain <= '0;
        end else begin
            state  <= state_nxt;
            remain <= remain_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt  = state;
        remain_nxt = remain;
        unique case (state)
            LS_IDLE: begin
                if (start_div) begin
                    state_nxt  = LS_DIV_BUSY;
                    remain_nxt = CW'(DIV_LAT - 1);
                end else if (start_sqrt) begin
                    state_nxt  = LS_SQRT_BUSY;
                    remain_nxt = CW'(SQRT_LAT - 1);
                end
            end
            LS_DIV_BUSY, LS_SQRT_BUSY: begin
                if (remain <= CW'(1)) begin
                    state_nxt  = LS_IDLE;
                    remain_nxt = '0;
                end else begin
                    remain_nxt = remain - CW'(1);
                end
            end
            default: begin
                state_nxt  = LS_IDLE;
                remain_nxt = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ready = (state == LS_IDLE);
    end

endmodule

// File: rtl/disp_port_steer.sv
module disp_port_steer
    import disp_pkg::*;
#(
    parameter int SLOTS    = 5,
    parameter int TAG_W    = 6,
    parameter int ADD_LAT  = 3,
    parameter int MUL_LAT  = 5,
    parameter int DIV_LAT  = 18,
    parameter int SQRT_LAT = 29
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLOTS-1:0]           uop_valid,
    input  logic [SLOTS*CLASS_W-1:0]   uop_class,
    input  logic [SLOTS*TAG_W-1:0]     uop_tag,
    output logic [SLOTS-1:0]           slot_grant,
    output logic [NUM_PORTS-1:0]       port_fire,
    output logic [NUM_PORTS*TAG_W-1:0] port_tag,
    output logic                       done_valid,
    output logic [TAG_W-1:0]           done_tag
);

    localparam int MAX_LAT    = max_of(max_of(ADD_LAT, MUL_LAT), max_of(DIV_LAT, SQRT_LAT));
    localparam int RING_DEPTH = MAX_LAT + 1;
    localparam int RIDX_W     = $clog2(RING_DEPTH);

    logic [SLOTS-1:0] is_alu, is_full, fp_ok;
    logic [SLOTS-1:0] mem_req [NUM_MEM];
    logic [3:0]       probe_free;
    logic             lng_ready;

    // per-slot decode
    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        logic [CLASS_W-1:0] cls;
        assign cls        = uop_class[g*CLASS_W +: CLASS_W];
        assign is_alu[g]  = uop_valid[g] && (cls == UC_ALU);
        assign is_full[g] = uop_valid[g] && (cls == UC_ALU_FULL);
        assign fp_ok[g]   = uop_valid[g] && (
                              ((cls == UC_FADD)  && probe_free[0]) ||
                              ((cls == UC_FMUL)  && probe_free[1]) ||
                              ((cls == UC_FDIV)  && lng_ready && probe_free[2]) ||
                              ((cls == UC_FSQRT) && lng_ready && probe_free[3]));
        for (genvar k = 0; k < NUM_MEM; k++) begin : g_mem
            assign mem_req[k][g] = uop_valid[g] && (cls == mem_class(k));
        end
    end

    // simple-integer port picks first
    logic [SLOTS-1:0] p1_win;
    logic             p1_any;
    logic [TAG_W-1:0] p1_tag;

    disp_oldest_pick #(.N(SLOTS), .TAG_W(TAG_W)) u_pick_alu (
        .req(is_alu), .tags(uop_tag), .win(p1_win), .any(p1_any), .win_tag(p1_tag)
    );

    // shared integer / FP port takes the oldest remaining candidate
    logic [SLOTS-1:0] p0_req, p0_win;
    logic             p0_any;
    logic [TAG_W-1:0] p0_tag;

    assign p0_req = (is_full | fp_ok | is_alu) & ~p1_win;

    disp_oldest_pick #(.N(SLOTS), .TAG_W(TAG_W)) u_pick_shared (
        .req(p0_req), .tags(uop_tag), .win(p0_win), .any(p0_any), .win_tag(p0_tag)
    );

    // memory ports
    logic [SLOTS-1:0] mem_win [NUM_MEM];
    logic [NUM_MEM-1:0] mem_any;
    logic [TAG_W-1:0] mem_tag [NUM_MEM];

    for (genvar k = 0; k < NUM_MEM; k++) begin : g_mport
        disp_oldest_pick #(.N(SLOTS), .TAG_W(TAG_W)) u_pick_mem (
            .req(mem_req[k]), .tags(uop_tag), .win(mem_win[k]),
            .any(mem_any[k]), .win_tag(mem_tag[k])
        );
    end

    // FP issue bookkeeping for the shared-port winner
    logic [CLASS_W-1:0] win_cls;
    logic               rsv_en, start_div, start_sqrt;
    int                 rsv_lat;
    logic [RIDX_W-1:0]  rsv_idx;

    always_comb begin
        win_cls = UC_ALU;
        for (int i = 0; i < SLOTS; i++) begin
            if (p0_win[i]) win_cls = uop_class[i*CLASS_W +: CLASS_W];
        end
        rsv_en     = 1'b0;
        rsv_lat    = 1;
        start_div  = 1'b0;
        start_sqrt = 1'b0;
        if (p0_any) begin
            case (win_cls)
                UC_FADD:  begin rsv_en = 1'b1; rsv_lat = ADD_LAT; end
                UC_FMUL:  begin rsv_en = 1'b1; rsv_lat = MUL_LAT; end
                UC_FDIV:  begin rsv_en = 1'b1; rsv_lat = DIV_LAT;  start_div  = 1'b1; end
                UC_FSQRT: begin rsv_en = 1'b1; rsv_lat = SQRT_LAT; start_sqrt = 1'b1; end
                default:  ;
            endcase
        end
        rsv_idx = RIDX_W'(rsv_lat - 1);
    end

    disp_wb_ring #(.DEPTH(RING_DEPTH), .TAG_W(TAG_W), .NPROBE(4)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsv_en     (rsv_en),
        .rsv_idx    (rsv_idx),
        .rsv_tag    (p0_tag),
        .probe_idx  ({RIDX_W'(SQRT_LAT), RIDX_W'(DIV_LAT), RIDX_W'(MUL_LAT), RIDX_W'(ADD_LAT)}),
        .probe_free (probe_free),
        .head_valid (done_valid),
        .head_tag   (done_tag)
    );

    disp_longop_fsm #(.DIV_LAT(DIV_LAT), .SQRT_LAT(SQRT_LAT)) u_long (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_div  (start_div),
        .start_sqrt (start_sqrt),
        .ready      (lng_ready)
    );

    // outputs
    always_comb begin
        slot_grant = p0_win | p1_win;
        for (int k = 0; k < NUM_MEM; k++) slot_grant = slot_grant | mem_win[k];
        port_fire = '0;
        port_tag  = '0;
        port_fire[PORT_SHARED] = p0_any;
        port_fire[PORT_ALU]    = p1_any;
        port_tag[PORT_SHARED*TAG_W +: TAG_W] = p0_tag;
        port_tag[PORT_ALU*TAG_W    +: TAG_W] = p1_tag;
        for (int k = 0; k < NUM_MEM; k++) begin
            port_fire[PORT_MEM0 + k]                 = mem_any[k];
            port_tag[(PORT_MEM0 + k)*TAG_W +: TAG_W] = mem_tag[k];
        end
    end

endmodule

// File: rtl/disp_port_steer_chk.sv
module disp_port_steer_chk
    import disp_pkg::*;
#(
    parameter int SLOTS    = 5,
    parameter int TAG_W    = 6,
    parameter int DIV_LAT  = 18,
    parameter int SQRT_LAT = 29
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [SLOTS-1:0]         uop_valid,
    input logic [SLOTS*CLASS_W-1:0] uop_class,
    input logic [SLOTS-1:0]         slot_grant,
    input logic [NUM_PORTS-1:0]     port_fire,
    input logic                     done_valid,
    input logic [TAG_W-1:0]         done_tag
);

    localparam int CW = $clog2(max_of(DIV_LAT, SQRT_LAT) + 1);

    logic [SLOTS-1:0] fp_g, long_g, div_g, bad_g;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            fp_g[i]   = slot_grant[i] && (uop_class[i*CLASS_W +: CLASS_W] >= UC_FADD)
                                      && (uop_class[i*CLASS_W +: CLASS_W] <= UC_FSQRT);
            div_g[i]  = slot_grant[i] && (uop_class[i*CLASS_W +: CLASS_W] == UC_FDIV);
            long_g[i] = div_g[i] || (slot_grant[i] && (uop_class[i*CLASS_W +: CLASS_W] == UC_FSQRT));
            bad_g[i]  = slot_grant[i] && (uop_class[i*CLASS_W +: CLASS_W] > UC_STDATA);
        end
    end

    // cycles left before the long unit may accept again
    logic [CW-1:0] gap;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         gap <= '0;
        else if (|long_g)   gap <= (|div_g) ? CW'(DIV_LAT - 1) : CW'(SQRT_LAT - 1);
        else if (gap != '0) gap <= gap - CW'(1);
    end

    a_r1_no_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
        bad_g == '0);

    a_r3_single_fp: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fp_g) <= 1);

    a_r4_grant_port_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_grant) == $countones(port_fire));

    a_r8_long_unit_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (gap != '0) |-> (long_g == '0));

    a_r11_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_grant & ~uop_valid) == '0);

    a_r5_done_tag_known: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !$isunknown(done_tag));

endmodule

bind disp_port_steer disp_port_steer_chk #(
    .SLOTS(SLOTS), .TAG_W(TAG_W), .DIV_LAT(DIV_LAT), .SQRT_LAT(SQRT_LAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uop_valid  (uop_valid),
    .uop_class  (uop_class),
    .slot_grant (slot_grant),
    .port_fire  (port_fire),
    .done_valid (done_valid),
    .done_tag   (done_tag)
);

// File: tb/disp_port_steer_test.sv
module disp_port_steer_test;

    localparam int NS = 5;
    localparam int TW = 6;
    localparam int LA = 3, LM = 5, LD = 18, LQ = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0]    uop_valid;
    logic [NS*4-1:0]  uop_class;
    logic [NS*TW-1:0] uop_tag;
    logic [NS-1:0]    slot_grant;
    logic [4:0]       port_fire;
    logic [5*TW-1:0]  port_tag;
    logic             done_valid;
    logic [TW-1:0]    done_tag;

    disp_port_steer uut (
        .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_class(uop_class),
        .uop_tag(uop_tag), .slot_grant(slot_grant), .port_fire(port_fire),
        .port_tag(port_tag), .done_valid(done_valid), .done_tag(done_tag)
    );

    always #5 clk = ~clk;

    // pool slots and reference state
    bit        sv [NS];
    logic [3:0] sc [NS];
    logic [TW-1:0] st [NS];
    bit        eg [NS];
    bit        rv [64];
    logic [TW-1:0] rt [64];
    int        long_free;
    int        cyc;
    int        ntag;
    int        nchk;
    int        nerr;
    bit        finished;

    task automatic chk(input string lab, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s cycle %0d %s actual=%0h expected=%0h", lab, cyc, what, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [3:0] c);
        case (c)
            4'd2: return LA;
            4'd3: return LM;
            4'd4: return LD;
            default: return LQ;
        endcase
    endfunction

    function automatic bit fp_ready(input logic [3:0] c);
        int l;
        if (c < 4'd2 || c > 4'd5) return 1'b0;
        l = lat_of(c);
        if (c >= 4'd4 && cyc < long_free) return 1'b0;
        return !rv[(cyc + l) % 64];
    endfunction

    function automatic int pick(input bit c [NS]);
        int b = -1;
        for (int i = 0; i < NS; i++)
            if (c[i] && (b < 0 || st[i] < st[b])) b = i;
        return b;
    endfunction

    task automatic apply();
        for (int i = 0; i < NS; i++) begin
            uop_valid[i]          = sv[i];
            uop_class[i*4 +: 4]   = sc[i];
            uop_tag[i*TW +: TW]   = st[i];
        end
    endtask

    task automatic put_t(input int i, input logic [3:0] c, input logic [TW-1:0] t);
        sv[i] = 1'b1; sc[i] = c; st[i] = t;
    endtask

    task automatic put(input int i, input logic [3:0] c);
        put_t(i, c, ntag[TW-1:0]);
        ntag++;
    endtask

    task automatic evaluate(input string lab);
        bit c1 [NS];
        bit c0 [NS];
        bit cm [NS];
        int p1, p0, l;
        int pw [5];
        logic [NS-1:0] egv;
        logic [4:0]    efire;
        for (int i = 0; i < NS; i++) c1[i] = sv[i] && sc[i] == 4'd0;
        p1 = pick(c1);
        for (int i = 0; i < NS; i++)
            c0[i] = sv[i] && i != p1 && (sc[i] == 4'd0 || sc[i] == 4'd1 || fp_ready(sc[i]));
        p0 = pick(c0);
        pw[0] = p0; pw[1] = p1;
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < NS; i++) cm[i] = sv[i] && sc[i] == 4'(6 + k);
            pw[2 + k] = pick(cm);
        end
        egv = '0; efire = '0;
        for (int i = 0; i < NS; i++) eg[i] = 1'b0;
        for (int p = 0; p < 5; p++) begin
            if (pw[p] >= 0) begin
                efire[p] = 1'b1; egv[pw[p]] = 1'b1; eg[pw[p]] = 1'b1;
            end
        end
        chk(lab, slot_grant === egv, "slot_grant", 32'(slot_grant), 32'(egv));
        chk(lab, port_fire === efire, "port_fire", 32'(port_fire), 32'(efire));
        for (int p = 0; p < 5; p++)
            if (pw[p] >= 0)
                chk(lab, port_tag[p*TW +: TW] === st[pw[p]], $sformatf("port%0d tag", p),
                    32'(port_tag[p*TW +: TW]), 32'(st[pw[p]]));
        chk(lab, done_valid === rv[cyc % 64], "done_valid", 32'(done_valid), 32'(rv[cyc % 64]));
        if (rv[cyc % 64])
            chk(lab, done_tag === rt[cyc % 64], "done_tag", 32'(done_tag), 32'(rt[cyc % 64]));
        rv[cyc % 64] = 1'b0;
        if (p0 >= 0 && sc[p0] >= 4'd2 && sc[p0] <= 4'd5) begin
            l = lat_of(sc[p0]);
            rv[(cyc + l) % 64] = 1'b1;
            rt[(cyc + l) % 64] = st[p0];
            if (sc[p0] >= 4'd4) long_free = cyc + l;
        end
    endtask

    task automatic step(input string lab, input bit refill);
        apply();
        @(negedge clk);
        evaluate(lab);
        @(posedge clk);
        #1;
        cyc++;
        for (int i = 0; i < NS; i++) begin
            if (eg[i] || sc[i] > 4'd8) sv[i] = 1'b0;
            if (refill && !sv[i] && ($urandom_range(0, 3) != 0)) begin
                int r = $urandom_range(0, 19);
                logic [3:0] c;
                if (r < 5 || r > 17) c = 4'd0;
                else if (r < 7)      c = 4'd1;
                else if (r < 11)     c = 4'(r - 5);
                else if (r < 13)     c = 4'd6;
                else if (r < 15)     c = 4'd7;
                else if (r < 17)     c = 4'd8;
                else                 c = 4'd12;
                put(i, c);
            end
        end
    endtask

    task automatic clear_slots();
        for (int i = 0; i < NS; i++) begin sv[i] = 1'b0; sc[i] = 4'd15; st[i] = '0; end
    endtask

    task automatic run(input string lab, input int n);
        for (int k = 0; k < n; k++) step(lab, 1'b0);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            nerr++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        nchk = 0; nerr = 0; ntag = 0; cyc = 0; long_free = 0; finished = 1'b0;
        for (int j = 0; j < 64; j++) begin rv[j] = 1'b0; rt[j] = '0; end
        clear_slots();
        apply();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", done_valid === 1'b0, "done_valid in reset", 32'(done_valid), 0);
        chk("R10", port_fire === 5'd0, "port_fire in reset", 32'(port_fire), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        cyc = 0;
        run("R10", 2);

        // invalid slots carrying real classes
        put(0, 4'd1); put(1, 4'd2); put(2, 4'd6); put(3, 4'd0); put(4, 4'd4);
        for (int i = 0; i < NS; i++) sv[i] = 1'b0;
        run("R11", 2);

        // class to port mapping, illegal code ignored
        put(0, 4'd6); put(1, 4'd7); put(2, 4'd8); put(3, 4'd1); put(4, 4'd12);
        step("R1", 1'b0);
        sv[4] = 1'b0;
        run("R1", 1);

        // age ordering
        clear_slots();
        put_t(0, 4'd6, 6'd20); put_t(1, 4'd6, 6'd9); put_t(2, 4'd6, 6'd14);
        put_t(3, 4'd0, 6'd30); put_t(4, 4'd0, 6'd5);
        run("R2", 4);
        clear_slots();
        put_t(0, 4'd1, 6'd40); put_t(1, 4'd0, 6'd30); put_t(2, 4'd0, 6'd5);
        put_t(3, 4'd0, 6'd17);
        run("R2", 4);

        // shared-port mix
        clear_slots();
        put(0, 4'd2); put(1, 4'd3); put(2, 4'd0); put(3, 4'd0); put(4, 4'd1);
        run("R3", 12);

        // pipelined latencies
        clear_slots();
        put(0, 4'd2);
        run("R5", 5);
        put(1, 4'd3);
        run("R6", 7);

        // long ops, with add and multiply overlapping
        put(0, 4'd4);
        step("R7", 1'b0);
        put(1, 4'd2); put(2, 4'd3);
        run("R7", 20);
        put(0, 4'd5);
        run("R7", 31);

        // back-to-back long ops
        put(0, 4'd4); put(1, 4'd4); put(2, 4'd5);
        run("R8", 80);

        // writeback collision: multiply then add two cycles later
        clear_slots();
        put(0, 4'd3);
        step("R9", 1'b0);
        step("R9", 1'b0);
        put(1, 4'd2); put(2, 4'd1);
        run("R9", 8);

        // mixed traffic with refill
        for (int k = 0; k < 3000; k++) step("R4", 1'b1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule